// File: doc/BRIEF.md
# Pipelined Logarithmic Lane Rotator

This block moves a group of narrow lanes onto the same number of output lanes, turned by an amount taken from a small control word. With the default sizing it has eight lanes of four bits and a three-bit control. Input lane k lands on output lane (k + amount) mod 8. The rotation is not built from wide per-lane selectors. Instead, it is a cascade of log2(lanes) stages, each a bank of 2:1 multiplexers. The first stage turns by half the lane count under the top control bit, the next by a quarter, and the last by one lane under the bottom bit.

A build-time parameter selects the timing. In the flat variant the stages are combinational and only the last one is registered, so a result is visible one clock after its inputs are sampled. In the pipelined variant every stage is registered, which gives a fixed three-clock latency with a new word accepted each clock. The control word travels down the pipeline beside its data, so every stage uses the amount that came with that word. A valid flag travels alongside as well.

Top module: `lane_rotator`

## Requirements
- R1: Input lane k (bits [4k+3:4k] of `in_lanes`) appears on output lane (k + `in_shift`) mod 8 (bits of `out_lanes` at the same position rule), for every shift value 0 to 7.
- R2: A shift value of 0 leaves every lane in its own position, in both timing variants.
- R3: With PIPELINED=1 a word's result and flag appear on the outputs exactly 3 rising edges after the edge that samples it; with PIPELINED=0 after exactly 1 edge.
- R4: A new word with a different shift may be presented every clock; each result uses the shift that was sampled with its own data.
- R5: `out_valid` reproduces `in_valid` with the same latency as the data, including idle gaps and isolated one-cycle pulses.
- R6: While `rst_n` is low at a rising edge, all stage registers are cleared: `out_valid` and `out_lanes` read 0, and words in flight before the reset never raise `out_valid` afterwards.
- R7: Rotation neither creates nor loses bits: the number of set bits in a result equals that of the word it came from.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Marks the word on `in_lanes` as meaningful |
| in_shift | input | 3 | Rotation amount in lanes, toward higher lane numbers |
| in_lanes | input | 32 | Eight 4-bit lanes, lane k at bits [4k+3:4k] |
| out_valid | output | 1 | Flag that travelled with the word on `out_lanes` |
| out_lanes | output | 32 | Rotated lanes, same packing as the input |

## Verification
On every cycle, the assertions check that each stage preserves its set-bit count, that a registered stage passes the flag and the control word on by exactly one clock, and that the flag and control word reach the top-level outputs after the configured latency. The lane placement itself, meaning which lane ends up where for each amount, can only be shown by the bench comparing results against expected words. The same holds for reset dropping words in flight and for back-to-back words with different amounts staying correctly paired. Both timing variants are instantiated side by side and driven with the same stimulus.

// File: rtl/lane_rot_pkg.sv
// Package: lane_rot_pkg
// Shared defaults for the lane rotator and a helper that gives the number
// of control bits needed for a lane count. Assumes lane counts are powers
// of two.
package lane_rot_pkg;

    parameter int unsigned DEF_LANES  = 8;
    parameter int unsigned DEF_LANE_W = 4;

    // Control bits needed to address every rotation amount.
    function automatic int unsigned ctrl_bits(input int unsigned lanes);
        return (lanes <= 1) ? 1 : $clog2(lanes);
    endfunction

endpackage

// File: rtl/lane_rot_reg.sv
// Module: lane_rot_reg
// A word-wide stage boundary. When EN is 1 it is a register with a
// synchronous active-low clear. When EN is 0 it is a plain wire. This lets
// one stage body serve both the flat and the pipelined variant.
// Assumes: the clear value of every bit is zero.
module lane_rot_reg #(
    parameter int unsigned W  = 8,
    parameter bit          EN = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    generate
        if (EN) begin : g_flop
            // Capture the stage word, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) q <= '0;
                else        q <= d;
            end
        end else begin : g_wire
            assign q = d;
        end
    endgenerate

endmodule

// File: rtl/lane_rot_stage.sv
// Module: lane_rot_stage
// One layer of the logarithmic rotator. When control bit BIT of the carried
// shift word is set, the layer moves every lane up by 2**BIT positions with
// wrap-around. Otherwise the lanes pass straight through. Each lane has one
// 2:1 mux per data bit. The valid flag and the full shift word are carried
// to the next layer beside the data, optionally through a register.
// Assumes: 2**BIT < NL, and NL is a power of two.
module lane_rot_stage #(
    parameter int unsigned NL  = 8,
    parameter int unsigned LW  = 4,
    parameter int unsigned SW  = 3,
    parameter int unsigned BIT = 0,
    parameter bit          REG = 1'b1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             v_i,
    input  logic [SW-1:0]    sh_i,
    input  logic [NL*LW-1:0] d_i,
    output logic             v_o,
    output logic [SW-1:0]    sh_o,
    output logic [NL*LW-1:0] d_o
);

    localparam int unsigned DW   = NL * LW;
    localparam int unsigned DIST = 1 << BIT;
    localparam int unsigned PW   = 1 + SW + DW;

    logic [DW-1:0] rotated;
    logic [DW-1:0] picked;
    logic [PW-1:0] pack_i;
    logic [PW-1:0] pack_o;

    // Lane j of the rotated word comes from lane (j - DIST) mod NL.
    generate
        for (genvar j = 0; j < NL; j++) begin : g_lane
            assign rotated[j*LW +: LW] = d_i[((j + NL - DIST) % NL)*LW +: LW];
        end
    endgenerate

    // Layer mux: pass through or take the rotated copy.
    always_comb begin
        picked = sh_i[BIT] ? rotated : d_i;
    end

    assign pack_i = {v_i, sh_i, picked};

    lane_rot_reg #(.W(PW), .EN(REG)) u_bound (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (pack_i),
        .q     (pack_o)
    );

    assign {v_o, sh_o, d_o} = pack_o;

    generate
        if (REG) begin : g_chk_reg
            // Registered layer keeps the bit population of its input word.
            p_bits_kept_r7: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> ($countones(d_o) == $countones($past(d_i))));
            // Flag moves on exactly one clock later.
            p_valid_follow_r5: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (v_o == $past(v_i)));
            // Shift word travels with its data unchanged.
            p_shift_carry_r4: assert property (@(posedge clk) disable iff (!rst_n)
                $past(rst_n) |-> (sh_o == $past(sh_i)));
        end else begin : g_chk_comb
            // Combinational layer keeps the bit population of its input word.
            always_comb begin
                p_bits_kept_comb_r7: assert ($countones(d_o) == $countones(d_i));
            end
        end
    endgenerate

endmodule

// File: rtl/lane_rotator.sv
// Module: lane_rotator (top)
// Rotates NLANES lanes of LANE_W bits by in_shift positions toward higher
// lane numbers. The rotator is a cascade of log2(NLANES) mux layers,
// largest distance first. PIPELINED=1 registers every layer (latency equal
// to the layer count). PIPELINED=0 registers only the last layer
// (latency 1). Assumes NLANES is a power of two of at least 2.
module lane_rotator
    import lane_rot_pkg::*;
#(
    parameter int unsigned NLANES    = DEF_LANES,
    parameter int unsigned LANE_W    = DEF_LANE_W,
    parameter bit          PIPELINED = 1'b1
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          in_valid,
    input  logic [ctrl_bits(NLANES)-1:0]  in_shift,
    input  logic [NLANES*LANE_W-1:0]      in_lanes,
    output logic                          out_valid,
    output logic [NLANES*LANE_W-1:0]      out_lanes
);

    localparam int unsigned SW  = ctrl_bits(NLANES);
    localparam int unsigned DW  = NLANES * LANE_W;
    localparam int unsigned LAT = PIPELINED ? SW : 1;

    logic          v_s  [SW+1];
    logic [SW-1:0] sh_s [SW+1];
    logic [DW-1:0] d_s  [SW+1];

    assign v_s[0]  = in_valid;
    assign sh_s[0] = in_shift;
    assign d_s[0]  = in_lanes;

    // Layer s handles control bit SW-1-s: distance NLANES/2 first, 1 last.
    generate
        for (genvar s = 0; s < SW; s++) begin : g_layer
            lane_rot_stage #(
                .NL  (NLANES),
                .LW  (LANE_W),
                .SW  (SW),
                .BIT (SW - 1 - s),
                .REG (PIPELINED || (s == SW - 1))
            ) u_stage (
                .clk   (clk),
                .rst_n (rst_n),
                .v_i   (v_s[s]),
                .sh_i  (sh_s[s]),
                .d_i   (d_s[s]),
                .v_o   (v_s[s+1]),
                .sh_o  (sh_s[s+1]),
                .d_o   (d_s[s+1])
            );
        end
    endgenerate

    assign out_valid = v_s[SW];
    assign out_lanes = d_s[SW];

    // Checker state: clocks since reset released, saturating at LAT.
    logic [7:0] run_cnt;
    always_ff @(posedge clk) begin
        if (!rst_n)               run_cnt <= '0;
        else if (run_cnt < 8'(LAT)) run_cnt <= run_cnt + 8'd1;
    end

    // Flag and control word emerge exactly LAT clocks after they enter.
    p_latency_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (run_cnt >= 8'(LAT)) |->
            ((out_valid == $past(in_valid, LAT)) && (sh_s[SW] == $past(in_shift, LAT))));

endmodule

// File: tb/lane_rotator_tb.sv
// Bench: drives the pipelined (u_dut) and flat (u_dut_flat) variants with
// the same stimulus and compares both against expected words.
module lane_rotator_tb;

    localparam int CLK_P = 10;
    localparam int N     = 12;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [2:0]  in_shift;
    logic [31:0] in_lanes;
    logic        p_valid, f_valid;
    logic [31:0] p_lanes, f_lanes;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    // Stimulus table: input word, shift, expected rotated word.
    localparam logic [31:0] VEC_IN [N] = '{
        32'h76543210, 32'h76543210, 32'h76543210, 32'h76543210,
        32'h76543210, 32'h76543210, 32'h76543210, 32'h76543210,
        32'hDEADBEEF, 32'h0000000F, 32'hA0000000, 32'hFFFF0000 };
    localparam logic [2:0] VEC_SH [N] = '{
        3'd0, 3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6, 3'd7,
        3'd0, 3'd5, 3'd1, 3'd2 };
    localparam logic [31:0] VEC_EXP [N] = '{
        32'h76543210, 32'h65432107, 32'h54321076, 32'h43210765,
        32'h32107654, 32'h21076543, 32'h10765432, 32'h07654321,
        32'hDEADBEEF, 32'h00F00000, 32'h0000000A, 32'hFF0000FF };

    always #(CLK_P/2) clk = ~clk;

    lane_rotator #(.NLANES(8), .LANE_W(4), .PIPELINED(1'b1)) u_dut (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_shift (in_shift),
        .in_lanes (in_lanes), .out_valid (p_valid), .out_lanes (p_lanes)
    );

    lane_rotator #(.NLANES(8), .LANE_W(4), .PIPELINED(1'b0)) u_dut_flat (
        .clk (clk), .rst_n (rst_n), .in_valid (in_valid), .in_shift (in_shift),
        .in_lanes (in_lanes), .out_valid (f_valid), .out_lanes (f_lanes)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic drive(input logic v, input logic [2:0] sh, input logic [31:0] d);
        in_valid = v;
        in_shift = sh;
        in_lanes = d;
    endtask

    initial begin
        rst_n = 1'b0;
        drive(1'b0, 3'd0, 32'h0);
        repeat (3) @(negedge clk);
        // R6: reset state of both variants.
        check(p_valid == 1'b0 && p_lanes == 32'h0, "R6 pipe reset", {p_valid, p_lanes[30:0]}, 32'h0);
        check(f_valid == 1'b0 && f_lanes == 32'h0, "R6 flat reset", {f_valid, f_lanes[30:0]}, 32'h0);
        rst_n = 1'b1;

        // Table walk, back to back: R1, R2, R3, R4, R5, R7.
        for (int i = 0; i < N + 3; i++) begin
            @(negedge clk);
            if (i >= 1 && i - 1 < N) begin
                check(f_lanes == VEC_EXP[i-1], (VEC_SH[i-1] == 0) ? "R2 flat" : "R1 R3 flat",
                      f_lanes, VEC_EXP[i-1]);
                check(f_valid == 1'b1, "R5 flat valid", 32'(f_valid), 32'h1);
            end else if (i >= 1) begin
                check(f_valid == 1'b0, "R5 flat idle", 32'(f_valid), 32'h0);
            end
            if (i >= 3 && i - 3 < N) begin
                check(p_lanes == VEC_EXP[i-3], (VEC_SH[i-3] == 0) ? "R2 pipe" : "R1 R3 R4 pipe",
                      p_lanes, VEC_EXP[i-3]);
                check(p_valid == 1'b1, "R5 pipe valid", 32'(p_valid), 32'h1);
                // R7: set-bit count is kept.
                check($countones(p_lanes) == $countones(VEC_IN[i-3]), "R7 bit count",
                      32'($countones(p_lanes)), 32'($countones(VEC_IN[i-3])));
            end else begin
                check(p_valid == 1'b0, "R5 pipe idle", 32'(p_valid), 32'h0);
            end
            if (i < N) drive(1'b1, VEC_SH[i], VEC_IN[i]);
            else       drive(1'b0, 3'd0, 32'h0);
        end

        // R5 and R3: isolated one-cycle pulse through the pipelined variant.
        @(negedge clk);
        drive(1'b1, 3'd5, 32'h0000000F);
        for (int k = 1; k <= 4; k++) begin
            @(negedge clk);
            if (k == 1) drive(1'b0, 3'd0, 32'h0);
            check(p_valid == (k == 3), "R5 R3 pulse valid", 32'(p_valid), 32'(k == 3));
            if (k == 3) check(p_lanes == 32'h00F00000, "R3 pulse data", p_lanes, 32'h00F00000);
        end

        // R6: reset with a word in flight drops it.
        @(negedge clk);
        drive(1'b1, 3'd3, 32'h12345678);
        @(negedge clk);
        drive(1'b0, 3'd0, 32'h0);
        rst_n = 1'b0;
        @(negedge clk);
        check(p_valid == 1'b0 && p_lanes == 32'h0, "R6 pipe cleared", p_lanes, 32'h0);
        check(f_valid == 1'b0 && f_lanes == 32'h0, "R6 flat cleared", f_lanes, 32'h0);
        rst_n = 1'b1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check(p_valid == 1'b0, "R6 in-flight dropped", 32'(p_valid), 32'h0);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_P * 5000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    end

endmodule